// File: doc/BRIEF.md
# Mixed-Sign Registered Multiplier

This block multiplies two 16-bit operands into a 32-bit product. Each operand sits in its own input register. Each operand also carries its own flag that marks it as two's complement or unsigned, so signed-by-unsigned products come out right. Between the operand registers and the product registers, a combinational stage can apply two controls:

- **Rounding** adds a half unit at the position just below the high half.
- **Format adjust** drops the duplicated sign bit, so the high half gains one bit of precision.

The product is held as a high half and a low half. A select line chooses which half appears on the 16-bit product port. The low half can also be driven back onto the Y operand bus, so a later operation can reuse it as an operand.

A feedthrough control bypasses the product registers. The product port then follows the multiplier output directly.

Each three-state bus is modelled as a data vector plus an active-high drive flag. An undriven bus reads as zero at the block's output.

The block is a datapath without sequencing states. Its timing is set entirely by the three load enables, one for X, one for Y and one for the product.

Top module: `mmul_top`

## Requirements
- R1: While `rst_n` is low, every register clears to zero: both operands, both sign flags and both product halves. With `p_oe`=1 and `ft`=0 the product port then reads 0 for either value of `hi_sel`.
- R2: On a rising clock edge, `en_x`=1 captures `x_in` and `x_tc`, and `en_y`=1 captures the Y bus and `y_tc`. When its enable is 0, an operand register and its flag keep their values.
- R3: An operand whose flag is 1 is read as two's complement, and one whose flag is 0 as unsigned. The 32-bit product is the low 32 bits of the true product. With `en_p`=1 at a rising edge, bits [31:16] load into the high half and bits [15:0] into the low half. With `en_p`=0 both halves hold.
- R4: When `rnd`=1 and `fadj`=0, 2^15 is added to the product before it is registered. The sum wraps modulo 2^32.
- R5: When `fadj`=1, with P the product after rounding, the high half becomes P[30:15] and the low half becomes {P[31], P[14:0]}. When `rnd`=1 in this mode, 2^14 is added in place of 2^15.
- R6: When `ft`=1, both halves seen at the outputs are the combinational product of the current operand registers and the current `rnd`/`fadj`, not the product registers. The product registers still load on `en_p`.
- R7: When `p_oe`=1, `p_out` carries the high half if `hi_sel`=1 and the low half if `hi_sel`=0. `p_drive` equals `p_oe`, and `p_out` is 0 when `p_oe`=0.
- R8: When `y_oe`=1, `y_drive`=1 and `y_out` carries the visible low half, and a Y load captures that low half in place of `y_in`. When `y_oe`=0, `y_drive`=0, `y_out`=0, and Y loads from `y_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every register |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand bus when the block is not driving it |
| x_tc | input | 1 | X is two's complement (1) or unsigned (0) |
| y_tc | input | 1 | Y is two's complement (1) or unsigned (0) |
| en_x | input | 1 | Load X register and its flag |
| en_y | input | 1 | Load Y register and its flag |
| en_p | input | 1 | Load both product halves |
| rnd | input | 1 | Round before the product register |
| fadj | input | 1 | Drop the redundant sign bit |
| ft | input | 1 | Feedthrough: bypass product registers |
| hi_sel | input | 1 | Product port shows high half (1) or low half (0) |
| p_oe | input | 1 | Product port drive request |
| y_oe | input | 1 | Drive the low half onto the Y bus |
| p_out | output | 16 | Product port data |
| p_drive | output | 1 | Product port is driven |
| y_out | output | 16 | Data driven onto the Y bus |
| y_drive | output | 1 | Y bus is driven by the block |

## Verification
All four sign-flag combinations are exercised with rounding both off and on. The operands are the most negative value, all ones, the most positive value, one, zero, and random values; mixing all-ones with the most negative value separates a sign-extension fault from a zero-extension fault. Format adjust, run with and without rounding on negative products, shows whether the shift, the sign copy into the low half, and the halved rounding weight are each right. Feedthrough runs with the product enable held low, and the Y bus test captures the low half as a new operand; together these separate the bypass and feedback paths from the registered path.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

    typedef struct packed {
        logic rnd;
        logic fadj;
    } mmul_mode_t;

    // Weight added for rounding: half a unit of the high half (R4, R5)
    function automatic logic [63:0] round_weight(input int unsigned w, input mmul_mode_t m);
        logic [63:0] one;
        one = 64'd1;
        if (!m.rnd)
            return 64'd0;
        return m.fadj ? (one << (w - 2)) : (one << (w - 1));
    endfunction

endpackage

// File: rtl/mmul_opreg.sv
module mmul_opreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    input  logic         tc_d,
    output logic [W-1:0] q,
    output logic         tc_q
);

    // R1, R2: operand and sign flag captured together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            tc_q <= 1'b0;
        end else if (en) begin
            q    <= d;
            tc_q <= tc_d;
        end
    end

endmodule

// File: rtl/mmul_array.sv
module mmul_array
    import mmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         a_tc,
    input  logic         b_tc,
    input  mmul_mode_t   mode,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);

    localparam int EW = W + 1;
    localparam int PW = 2 * W;

    logic signed [EW-1:0]   ea;
    logic signed [EW-1:0]   eb;
    logic signed [2*EW-1:0] full;
    logic [63:0]            rw;
    logic [PW-1:0]          raw;
    logic [PW-1:0]          sum;

    // R3: one extra bit per operand covers every sign combination
    always_comb begin
        ea   = {a_tc & a[W-1], a};
        eb   = {b_tc & b[W-1], b};
        full = ea * eb;
        raw  = full[PW-1:0];
        rw   = round_weight(W, mode);
        sum  = raw + rw[PW-1:0];
    end

    // R5: format adjust drops the redundant sign bit
    always_comb begin
        if (mode.fadj) begin
            hi = sum[PW-2:W-1];
            lo = {sum[PW-1], sum[W-2:0]};
        end else begin
            hi = sum[PW-1:W];
            lo = sum[W-1:0];
        end
    end

endmodule

// File: rtl/mmul_prodreg.sv
module mmul_prodreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         ft,
    input  logic [W-1:0] hi_d,
    input  logic [W-1:0] lo_d,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_v,
    output logic [W-1:0] lo_v
);

    // R1, R3: one enable loads both halves together
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (en) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    // R6: feedthrough bypasses the stored halves
    always_comb begin
        hi_v = ft ? hi_d : hi_q;
        lo_v = ft ? lo_d : lo_q;
    end

endmodule

// File: rtl/mmul_top.sv
module mmul_top
    import mmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         x_tc,
    input  logic         y_tc,
    input  logic         en_x,
    input  logic         en_y,
    input  logic         en_p,
    input  logic         rnd,
    input  logic         fadj,
    input  logic         ft,
    input  logic         hi_sel,
    input  logic         p_oe,
    input  logic         y_oe,
    output logic [W-1:0] p_out,
    output logic         p_drive,
    output logic [W-1:0] y_out,
    output logic         y_drive
);

    logic [W-1:0] x_q;
    logic [W-1:0] y_q;
    logic         x_tc_q;
    logic         y_tc_q;
    logic [W-1:0] y_src;
    logic [W-1:0] hi_comb;
    logic [W-1:0] lo_comb;
    logic [W-1:0] hi_reg;
    logic [W-1:0] lo_reg;
    logic [W-1:0] hi_vis;
    logic [W-1:0] lo_vis;
    mmul_mode_t   mode;

    // R8: the Y bus carries the low half whenever the block drives it
    assign y_src = y_oe ? lo_vis : y_in;
    assign mode  = '{rnd: rnd, fadj: fadj};

    mmul_opreg #(.W(W)) u_xreg (
        .clk(clk), .rst_n(rst_n), .en(en_x),
        .d(x_in), .tc_d(x_tc), .q(x_q), .tc_q(x_tc_q)
    );

    mmul_opreg #(.W(W)) u_yreg (
        .clk(clk), .rst_n(rst_n), .en(en_y),
        .d(y_src), .tc_d(y_tc), .q(y_q), .tc_q(y_tc_q)
    );

    mmul_array #(.W(W)) u_array (
        .a(x_q), .b(y_q), .a_tc(x_tc_q), .b_tc(y_tc_q),
        .mode(mode), .hi(hi_comb), .lo(lo_comb)
    );

    mmul_prodreg #(.W(W)) u_preg (
        .clk(clk), .rst_n(rst_n), .en(en_p), .ft(ft),
        .hi_d(hi_comb), .lo_d(lo_comb),
        .hi_q(hi_reg), .lo_q(lo_reg),
        .hi_v(hi_vis), .lo_v(lo_vis)
    );

    // R7, R8: output multiplexer and drive flags
    always_comb begin
        p_drive = p_oe;
        p_out   = '0;
        if (p_oe)
            p_out = hi_sel ? hi_vis : lo_vis;
        y_drive = y_oe;
        y_out   = y_oe ? lo_vis : '0;
    end

endmodule

// File: rtl/mmul_chk.sv
module mmul_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_x,
    input logic         en_p,
    input logic         ft,
    input logic         hi_sel,
    input logic         p_oe,
    input logic         y_oe,
    input logic [W-1:0] x_q,
    input logic [W-1:0] hi_reg,
    input logic [W-1:0] lo_reg,
    input logic [W-1:0] hi_comb,
    input logic [W-1:0] lo_comb,
    input logic [W-1:0] hi_vis,
    input logic [W-1:0] p_out,
    input logic         p_drive,
    input logic [W-1:0] y_out,
    input logic         y_drive
);

    a_r2_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_x |=> $stable(x_q));

    a_r3_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_p |=> ($stable(hi_reg) && $stable(lo_reg)));

    a_r3_prod_load: assert property (@(posedge clk) disable iff (!rst_n)
        en_p |=> (hi_reg == $past(hi_comb) && lo_reg == $past(lo_comb)));

    a_r6_feedthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ft |-> hi_vis == hi_comb);

    a_r7_hi_select: assert property (@(posedge clk) disable iff (!rst_n)
        (p_oe && hi_sel) |-> (p_out == hi_vis && p_drive));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !p_oe |-> (p_out == '0 && !p_drive));

    a_r8_y_release: assert property (@(posedge clk) disable iff (!rst_n)
        !y_oe |-> (y_out == '0 && !y_drive));

endmodule

bind mmul_top mmul_chk #(.W(W)) u_chk (.*);

// File: tb/sim_mmul_top.sv
`timescale 1ns/100ps
module sim_mmul_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x_in = '0, y_in = '0;
    logic         x_tc = 0, y_tc = 0, en_x = 0, en_y = 0, en_p = 0;
    logic         rnd = 0, fadj = 0, ft = 0, hi_sel = 0, p_oe = 0, y_oe = 0;
    logic [W-1:0] p_out, y_out;
    logic         p_drive, y_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mmul_top #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in),
        .x_tc(x_tc), .y_tc(y_tc), .en_x(en_x), .en_y(en_y), .en_p(en_p),
        .rnd(rnd), .fadj(fadj), .ft(ft), .hi_sel(hi_sel), .p_oe(p_oe),
        .y_oe(y_oe), .p_out(p_out), .p_drive(p_drive),
        .y_out(y_out), .y_drive(y_drive)
    );

    // Behavioural reference state
    int unsigned m_x, m_y, m_hi, m_lo;
    bit          m_xtc, m_ytc;

    function automatic longint unsigned ref_prod(int unsigned a, int unsigned b,
                                                 bit atc, bit btc, bit r, bit f);
        longint va, vb, p;
        longint unsigned u;
        va = (atc && a >= 32768) ? longint'(a) - 65536 : longint'(a);
        vb = (btc && b >= 32768) ? longint'(b) - 65536 : longint'(b);
        p  = va * vb;
        if (r) p = p + (f ? 16384 : 32768);
        u  = longint'(p) & 64'hFFFF_FFFF;
        if (f)
            return (((u >> 15) & 64'hFFFF) << 16) | (((u >> 31) & 1) << 15) | (u & 64'h7FFF);
        return u;
    endfunction

    function automatic longint unsigned vis_prod();
        if (ft) return ref_prod(m_x, m_y, m_xtc, m_ytc, rnd, fadj);
        return (longint'(m_hi) << 16) | longint'(m_lo);
    endfunction

    always @(posedge clk) begin
        longint unsigned nxt, vis;
        if (!rst_n) begin
            m_x = 0; m_y = 0; m_xtc = 0; m_ytc = 0; m_hi = 0; m_lo = 0;
        end else begin
            nxt = ref_prod(m_x, m_y, m_xtc, m_ytc, rnd, fadj);
            vis = vis_prod();
            if (en_x) begin m_x = x_in; m_xtc = x_tc; end
            if (en_y) begin m_y = y_oe ? int'(vis & 16'hFFFF) : int'(y_in); m_ytc = y_tc; end
            if (en_p) begin m_hi = int'(nxt >> 16); m_lo = int'(nxt & 16'hFFFF); end
        end
    end

    task automatic check_now(string tag);
        longint unsigned v;
        logic [W-1:0] ep, ey;
        v  = vis_prod();
        ep = !p_oe ? '0 : (hi_sel ? W'(v >> 16) : W'(v));
        ey = y_oe ? W'(v) : '0;
        checks++;
        if (p_out !== ep || p_drive !== p_oe || y_out !== ey || y_drive !== y_oe) begin
            errors++;
            $display("FAIL %s p_out=%h exp %h p_drive=%b exp %b y_out=%h exp %h y_drive=%b exp %b",
                     tag, p_out, ep, p_drive, p_oe, y_out, ey, y_drive, y_oe);
        end
    endtask

    // One clock: the edge uses the inputs set before it
    task automatic tick(string tag);
        @(negedge clk);
        #0.5;
        check_now(tag);
    endtask

    task automatic look(string tag);
        p_oe = 1; hi_sel = 1; #0.2; check_now(tag);
        hi_sel = 0; #0.2; check_now(tag);
    endtask

    task automatic mult(logic [W-1:0] a, logic [W-1:0] b, bit at, bit bt,
                        bit r, bit f, string tag);
        x_in = a; y_in = b; x_tc = at; y_tc = bt; en_x = 1; en_y = 1;
        tick("R2");
        en_x = 0; en_y = 0; rnd = r; fadj = f; en_p = 1;
        tick(tag);
        en_p = 0;
        look(tag);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] pat [6];
        logic [W-1:0] sh, sl;
        pat = '{16'h8000, 16'hFFFF, 16'h7FFF, 16'h0001, 16'h0000, 16'h1234};
        p_oe = 1; rnd = 1; en_p = 1;
        repeat (3) tick("R1");
        look("R1");
        en_p = 0; rnd = 0;
        rst_n = 1;
        tick("R1");

        // R3, R4: every sign combination, rounding off and on
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 6; i++)
                    mult(pat[i], pat[(i + c + 1) % 6], c[0], c[1], r[0], 1'b0,
                         r ? "R4" : "R3");
        for (int k = 0; k < 40; k++)
            mult(W'($urandom), W'($urandom), k[0], k[1], k[2], 1'b0, "R3");

        // R5: format adjust with negative products, rounding off and on
        mult(16'h8000, 16'h7FFF, 1, 1, 0, 1, "R5");
        mult(16'hFFFF, 16'h1234, 1, 0, 1, 1, "R5");
        mult(16'hC000, 16'h4001, 1, 1, 1, 1, "R5");
        mult(16'h8000, 16'h8000, 1, 1, 0, 1, "R5");
        for (int k = 0; k < 12; k++)
            mult(W'($urandom), W'($urandom), k[0], k[1], k[2], 1'b1, "R5");

        // R3: product halves hold with en_p low while operands change
        mult(16'h00FF, 16'h0101, 0, 0, 0, 0, "R3");
        sh = 0; sl = 0;
        x_in = 16'h7777; y_in = 16'h3333; en_x = 1; en_y = 1; rnd = 1;
        tick("R3");
        en_x = 0; en_y = 0;
        tick("R3");
        look("R3");
        rnd = 0;

        // R6: feedthrough follows operands and controls with en_p low
        ft = 1;
        look("R6");
        fadj = 1; look("R6");
        rnd = 1; look("R6");
        fadj = 0; rnd = 0;
        x_in = 16'hFFFE; x_tc = 1; en_x = 1;
        tick("R6");
        en_x = 0;
        look("R6");
        ft = 0;
        look("R6");

        // R7: port released
        p_oe = 0; hi_sel = 1; #0.2; check_now("R7");
        hi_sel = 0; #0.2; check_now("R7");
        p_oe = 1;

        // R8: low half on the Y bus and captured as the next Y operand
        mult(16'h0003, 16'h0005, 0, 0, 0, 0, "R8");
        y_oe = 1; y_in = 16'hAAAA; #0.2; check_now("R8");
        en_y = 1; y_tc = 0;
        tick("R8");
        en_y = 0; y_oe = 0; en_p = 1;
        tick("R8");
        en_p = 0;
        look("R8");
        y_oe = 1; ft = 1; #0.2; check_now("R8");
        y_oe = 0; ft = 0; #0.2; check_now("R8");

        // R2: X holds without its enable
        x_in = 16'h5555; en_p = 1;
        tick("R2");
        en_p = 0;
        look("R2");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule